// File: doc/BRIEF.md
# PHY Control-Register Access Master

This block performs one read or one write at a time on the slow control-register port of a serial PHY. Before, software did this work by toggling the port bit by bit. The host side presents a request with a direction bit, a 16-bit register address and 16-bit write data. It gets back a one-cycle done pulse, a timeout flag and the 16-bit read result.

The block makes the port clock itself, from the system clock. The clock exists only as discrete pulses, which the sequencer issues. Each pulse is high for `HALF_CYC` system clocks and low for at least that long.

Every transaction has the same stages:
- It first clears the port with a long burst of flush pulses.
- It raises select and then drives the address. For a write it also drives the data.
- It fires a single enable strobe with one clock pulse under it.
- It polls the acknowledge input. Every failed attempt costs one more clock pulse and a settling gap. The number of attempts is limited.

Top module: `phy_cr_master`

## Requirements
- R1: A transaction begins with exactly `FLUSH_PULSES` (default 100) port-clock pulses. During them select is low and the address bus, the write-data bus and both enables stay at zero.
- R2: Select rises one system clock before the address appears, so the address bus reads zero in the first cycle with select high. The captured address then holds until the enable strobe has been seen.
- R3: For a write, the write-data bus carries the captured data before write-enable rises, and it stays stable while write-enable is high.
- R4: Write-enable (for writes) or read-enable (for reads) is raised alone, never both at once. The enable is high before the clock rises, and exactly one port-clock pulse rises while it is high.
- R5: Acknowledge is sampled only after both enables are low. Each low sample is followed by one port-clock pulse and a gap of `GAP_CYC` system clocks before the next sample. A transaction whose acknowledge arrives after K failed samples (K < 10) therefore emits FLUSH_PULSES + 1 + K pulses in total.
- R6: After `ACK_TRIES` (default 10) low samples, each with its pulse and gap, the transaction ends with done and timeout both high. In that case the read result is zero and the pulse total is FLUSH_PULSES + 1 + ACK_TRIES.
- R7: On a read whose acknowledge is seen, the read-data bus value at that sample appears on `rdata_o` at done. It holds until the next accepted request. After a write `rdata_o` is zero.
- R8: `done_o` is high for exactly one cycle. In that cycle and afterwards, the port clock, select, enables, address bus and write-data bus are all low.
- R9: A request is accepted only while idle. A request raised during a transaction starts nothing: no second done and no further pulses.
- R10: Each port-clock pulse is high for exactly `HALF_CYC` system clocks and low for at least `HALF_CYC` system clocks before the next rise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Start a transaction (taken while idle) |
| wr_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 16 | Register address |
| wdata_i | input | 16 | Write data |
| rdata_o | output | 16 | Read result, valid at done |
| done_o | output | 1 | One-cycle end-of-transaction pulse |
| timeout_o | output | 1 | High with done when acknowledge never came |
| cr_clk_o | output | 1 | Generated port clock |
| cr_sel_o | output | 1 | Port select |
| cr_addr_o | output | 16 | Port address bus |
| cr_wdata_o | output | 16 | Port write-data bus |
| cr_wr_en_o | output | 1 | Write strobe |
| cr_rd_en_o | output | 1 | Read strobe |
| cr_ack_i | input | 1 | Acknowledge from the PHY |
| cr_rdata_i | input | 16 | Read data from the PHY |

## Verification
The bench sweeps the acknowledge latency from zero up past the retry limit, for both reads and writes, and counts every port-clock pulse.
- A retry counter that is off by one shows up in two ways. The pulse total comes out one too high or too low, or a latency of 9 or 10 lands on the wrong side of the timeout.
- A design that samples acknowledge before dropping the enable fails when the latency is zero.
- A design that drives the address together with select is caught at the select edge.
- A design that re-arms while busy is caught by a request injected mid-transaction. It produces a second done, or its write corrupts the register that is read back later.

// File: rtl/phy_cr_pkg.sv
package phy_cr_pkg;
  typedef enum logic [3:0] {
    ST_IDLE, ST_FLUSH, ST_SEL, ST_ADDR, ST_STROBE,
    ST_DROP, ST_SAMPLE, ST_POLL, ST_GAP, ST_FIN
  } cr_state_e;
endpackage

// File: rtl/phy_cr_pulse.sv
// One port-clock pulse per start: HALF_CYC high, HALF_CYC low.
module phy_cr_pulse #(
  parameter int HALF_CYC = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  output logic clk_o,
  output logic done_o
);
  localparam int CW = (2 * HALF_CYC > 1) ? $clog2(2 * HALF_CYC) : 1;
  localparam logic [CW-1:0] LAST = CW'(2 * HALF_CYC - 1);
  localparam logic [CW-1:0] HALF = CW'(HALF_CYC);

  logic          active_q;
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      cnt_q    <= '0;
    end else if (!active_q) begin
      if (start_i) begin
        active_q <= 1'b1;
        cnt_q    <= '0;
      end
    end else if (cnt_q == LAST) begin
      active_q <= 1'b0;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign clk_o  = active_q && (cnt_q < HALF);
  assign done_o = active_q && (cnt_q == LAST);
endmodule

// File: rtl/phy_cr_wait.sv
// Gap timer: expired_o is high in the CYC-th cycle after start_i.
module phy_cr_wait #(
  parameter int CYC = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  output logic expired_o
);
  localparam int WW = (CYC > 1) ? $clog2(CYC) : 1;

  logic          run_q;
  logic [WW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q <= 1'b0;
      cnt_q <= '0;
    end else if (start_i) begin
      run_q <= 1'b1;
      cnt_q <= WW'(CYC - 1);
    end else if (run_q) begin
      if (cnt_q == '0) run_q <= 1'b0;
      else             cnt_q <= cnt_q - 1'b1;
    end
  end

  assign expired_o = run_q && (cnt_q == '0);
endmodule

// File: rtl/phy_cr_master.sv
module phy_cr_master
  import phy_cr_pkg::*;
#(
  parameter int ADDR_W       = 16,
  parameter int DATA_W       = 16,
  parameter int FLUSH_PULSES = 100,
  parameter int ACK_TRIES    = 10,
  parameter int HALF_CYC     = 4,
  parameter int GAP_CYC      = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              done_o,
  output logic              timeout_o,
  output logic              cr_clk_o,
  output logic              cr_sel_o,
  output logic [ADDR_W-1:0] cr_addr_o,
  output logic [DATA_W-1:0] cr_wdata_o,
  output logic              cr_wr_en_o,
  output logic              cr_rd_en_o,
  input  logic              cr_ack_i,
  input  logic [DATA_W-1:0] cr_rdata_i
);
  localparam int FCW = $clog2(FLUSH_PULSES + 1);
  localparam int TCW = $clog2(ACK_TRIES + 1);
  localparam logic [FCW-1:0] FLUSH_LAST = FCW'(FLUSH_PULSES - 1);
  localparam logic [TCW-1:0] TRY_LIMIT  = TCW'(ACK_TRIES);

  cr_state_e         state_q;
  logic [FCW-1:0]    flush_q;
  logic [TCW-1:0]    tries_q;
  logic              wr_q;
  logic              to_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q;
  logic [DATA_W-1:0] rdata_q;

  logic pls_start, pls_done, gap_start, gap_exp;
  logic sel_win, bus_win;

  assign pls_start = (state_q == ST_FLUSH) || (state_q == ST_STROBE) || (state_q == ST_POLL);
  assign gap_start = (state_q == ST_POLL) && pls_done;

  phy_cr_pulse #(.HALF_CYC(HALF_CYC)) i_pulse (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (pls_start),
    .clk_o   (cr_clk_o),
    .done_o  (pls_done)
  );

  phy_cr_wait #(.CYC(GAP_CYC)) i_gap (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .start_i   (gap_start),
    .expired_o (gap_exp)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      flush_q <= '0;
      tries_q <= '0;
      wr_q    <= 1'b0;
      to_q    <= 1'b0;
      addr_q  <= '0;
      wdata_q <= '0;
      rdata_q <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (req_i) begin
          state_q <= ST_FLUSH;
          wr_q    <= wr_i;
          addr_q  <= addr_i;
          wdata_q <= wdata_i;
          flush_q <= '0;
          tries_q <= '0;
          to_q    <= 1'b0;
          rdata_q <= '0;
        end
        ST_FLUSH: if (pls_done) begin
          if (flush_q == FLUSH_LAST) state_q <= ST_SEL;
          else                       flush_q <= flush_q + 1'b1;
        end
        ST_SEL:    state_q <= ST_ADDR;
        ST_ADDR:   state_q <= ST_STROBE;
        ST_STROBE: if (pls_done) state_q <= ST_DROP;
        ST_DROP:   state_q <= ST_SAMPLE;
        ST_SAMPLE: begin
          if (cr_ack_i) begin
            if (!wr_q) rdata_q <= cr_rdata_i;
            state_q <= ST_FIN;
          end else begin
            tries_q <= tries_q + 1'b1;
            state_q <= ST_POLL;
          end
        end
        ST_POLL: if (pls_done) state_q <= ST_GAP;
        ST_GAP: if (gap_exp) begin
          if (tries_q == TRY_LIMIT) begin
            to_q    <= 1'b1;
            state_q <= ST_FIN;
          end else begin
            state_q <= ST_SAMPLE;
          end
        end
        ST_FIN:  state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  // Select covers SEL..GAP; buses are driven one cycle later.
  assign sel_win = (state_q == ST_SEL) || (state_q == ST_ADDR) || (state_q == ST_STROBE) ||
                   (state_q == ST_DROP) || (state_q == ST_SAMPLE) || (state_q == ST_POLL) ||
                   (state_q == ST_GAP);
  assign bus_win = sel_win && (state_q != ST_SEL);

  assign cr_sel_o   = sel_win;
  assign cr_addr_o  = bus_win ? addr_q : '0;
  assign cr_wdata_o = (bus_win && wr_q) ? wdata_q : '0;
  assign cr_wr_en_o = (state_q == ST_STROBE) && wr_q;
  assign cr_rd_en_o = (state_q == ST_STROBE) && !wr_q;

  assign done_o    = (state_q == ST_FIN);
  assign timeout_o = (state_q == ST_FIN) && to_q;
  assign rdata_o   = rdata_q;
endmodule

// File: rtl/phy_cr_master_chk.sv
module phy_cr_master_chk #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 16
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              done_o,
  input logic              timeout_o,
  input logic              cr_clk_o,
  input logic              cr_sel_o,
  input logic [ADDR_W-1:0] cr_addr_o,
  input logic [DATA_W-1:0] cr_wdata_o,
  input logic              cr_wr_en_o,
  input logic              cr_rd_en_o
);
  p_quiet_unselected_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cr_sel_o |-> (!cr_wr_en_o && !cr_rd_en_o && cr_addr_o == '0 && cr_wdata_o == '0));

  p_addr_after_sel_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(cr_sel_o) |-> (cr_addr_o == '0));

  p_wdata_stable_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cr_wr_en_o |-> $stable(cr_wdata_o));

  p_one_enable_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(cr_wr_en_o && cr_rd_en_o));

  p_enable_before_clk_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(cr_wr_en_o || cr_rd_en_o) |-> !cr_clk_o);

  p_timeout_qual_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    timeout_o |-> done_o);

  p_done_pulse_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  p_done_quiet_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (!cr_clk_o && !cr_sel_o && cr_addr_o == '0 && cr_wdata_o == '0));
endmodule

bind phy_cr_master phy_cr_master_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .done_o     (done_o),
  .timeout_o  (timeout_o),
  .cr_clk_o   (cr_clk_o),
  .cr_sel_o   (cr_sel_o),
  .cr_addr_o  (cr_addr_o),
  .cr_wdata_o (cr_wdata_o),
  .cr_wr_en_o (cr_wr_en_o),
  .cr_rd_en_o (cr_rd_en_o)
);

// File: tb/test_phy_cr_master.sv
`timescale 1ns/1ps
module test_phy_cr_master;
  localparam int HALF = 2;
  localparam int GAP  = 3;
  localparam int NFL  = 100;
  localparam int NTR  = 10;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req_i = 1'b0, wr_i = 1'b0;
  logic [15:0] addr_i = '0, wdata_i = '0;
  logic [15:0] rdata_o;
  logic        done_o, timeout_o;
  logic        cr_clk_o, cr_sel_o, cr_wr_en_o, cr_rd_en_o, cr_ack_i;
  logic [15:0] cr_addr_o, cr_wdata_o, cr_rdata_i;

  always #2 clk_i = ~clk_i;

  phy_cr_master #(.FLUSH_PULSES(NFL), .ACK_TRIES(NTR), .HALF_CYC(HALF), .GAP_CYC(GAP)) i_phy_cr_master (
    .clk_i(clk_i), .rst_ni(rst_ni), .req_i(req_i), .wr_i(wr_i), .addr_i(addr_i),
    .wdata_i(wdata_i), .rdata_o(rdata_o), .done_o(done_o), .timeout_o(timeout_o),
    .cr_clk_o(cr_clk_o), .cr_sel_o(cr_sel_o), .cr_addr_o(cr_addr_o),
    .cr_wdata_o(cr_wdata_o), .cr_wr_en_o(cr_wr_en_o), .cr_rd_en_o(cr_rd_en_o),
    .cr_ack_i(cr_ack_i), .cr_rdata_i(cr_rdata_i)
  );

  // Behavioural PHY register port
  logic [15:0] phy_mem [16];
  logic [15:0] exp_mem [16];
  int          k_ack = 0;
  logic        armed = 1'b0;
  int          pcnt = 0;
  logic [3:0]  rix = '0;

  initial for (int i = 0; i < 16; i++) begin
    phy_mem[i] = 16'h1000 + 16'(i) * 16'h0111;
    exp_mem[i] = 16'h1000 + 16'(i) * 16'h0111;
  end

  always @(posedge cr_clk_o) begin
    if (!cr_sel_o) begin
      armed <= 1'b0;
      pcnt  <= 0;
    end else if (cr_wr_en_o || cr_rd_en_o) begin
      armed <= 1'b1;
      pcnt  <= 0;
      rix   <= cr_addr_o[3:0];
      if (cr_wr_en_o) phy_mem[cr_addr_o[3:0]] <= cr_wdata_o;
    end else if (armed) begin
      pcnt <= pcnt + 1;
    end
  end
  assign cr_ack_i   = armed && (pcnt >= k_ack);
  assign cr_rdata_i = armed ? phy_mem[rix] : 16'hDEAD;

  // Port monitor, samples at negedge
  int          rises, rises_at_sel, en_rises, hi_run, lo_run, hi_bad, lo_bad, flush_bad, done_cnt;
  logic        prev_clk = 1'b0, prev_sel = 1'b0, prev_en = 1'b0;
  logic [15:0] addr_at_sel, addr_at_en, wd_at_en;
  logic        seen_wr, seen_rd;

  task automatic mon_clear();
    rises = 0; rises_at_sel = -1; en_rises = 0; hi_run = 0; lo_run = 1000;
    hi_bad = 0; lo_bad = 0; flush_bad = 0; done_cnt = 0;
    addr_at_sel = 16'hFFFF; addr_at_en = 16'hFFFF; wd_at_en = 16'hFFFF;
    seen_wr = 1'b0; seen_rd = 1'b0;
  endtask

  always @(negedge clk_i) begin
    if (cr_clk_o && !prev_clk) begin
      rises++;
      if (lo_run < HALF) lo_bad++;
      hi_run = 0;
      if (cr_wr_en_o || cr_rd_en_o) en_rises++;
    end
    if (!cr_clk_o && prev_clk) begin
      if (hi_run != HALF) hi_bad++;
      lo_run = 0;
    end
    if (cr_clk_o) hi_run++; else lo_run++;
    if (!cr_sel_o && (cr_wr_en_o || cr_rd_en_o || cr_addr_o != 0 || cr_wdata_o != 0)) flush_bad++;
    if (cr_sel_o && !prev_sel) begin
      rises_at_sel = rises;
      addr_at_sel  = cr_addr_o;
    end
    if ((cr_wr_en_o || cr_rd_en_o) && !prev_en) begin
      addr_at_en = cr_addr_o;
      wd_at_en   = cr_wdata_o;
      seen_wr    = cr_wr_en_o;
      seen_rd    = cr_rd_en_o;
    end
    if (done_o) done_cnt++;
    prev_clk = cr_clk_o;
    prev_sel = cr_sel_o;
    prev_en  = cr_wr_en_o || cr_rd_en_o;
  end

  int n_chk = 0, n_fail = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic bit quiet();
    return !cr_clk_o && !cr_sel_o && !cr_wr_en_o && !cr_rd_en_o && cr_addr_o == 0 && cr_wdata_o == 0;
  endfunction

  task automatic do_txn(input bit wr, input logic [15:0] a, input logic [15:0] d, input int k, input bit inj);
    int n, exp_p, r0;
    logic [15:0] exp_rd;
    k_ack = k;
    @(negedge clk_i); #1;
    mon_clear();
    req_i = 1'b1; wr_i = wr; addr_i = a; wdata_i = d;
    @(negedge clk_i);
    req_i = 1'b0; wr_i = ~wr; addr_i = ~a; wdata_i = ~d;
    n = 0;
    while (!done_o && n < 5000) begin
      @(negedge clk_i);
      n++;
      // R9: request mid-transaction must be ignored
      req_i = (inj && n == 30);
      if (inj && n == 30) begin wr_i = 1'b1; addr_i = 16'h0005; wdata_i = 16'hBAD0; end
    end
    req_i = 1'b0;
    #1;
    exp_p  = NFL + 1 + ((k < NTR) ? k : NTR);
    exp_rd = (!wr && k < NTR) ? exp_mem[a[3:0]] : 16'h0000;
    chk(n < 5000, "R8 done reached", n, 0);
    chk(rises_at_sel == NFL, "R1 flush pulses before select", rises_at_sel, NFL);
    chk(flush_bad == 0, "R1 outputs idle while unselected", flush_bad, 0);
    chk(addr_at_sel == 16'h0, "R2 address zero at select rise", addr_at_sel, 0);
    chk(addr_at_en == a, "R2 address at strobe", addr_at_en, a);
    if (wr) chk(wd_at_en == d, "R3 write data at strobe", wd_at_en, d);
    chk(en_rises == 1, "R4 one pulse under enable", en_rises, 1);
    chk(seen_wr == wr && seen_rd == !wr, "R4 enable kind", {seen_wr, seen_rd}, {wr, !wr});
    chk(rises == exp_p, (k < NTR) ? "R5 pulse total" : "R6 pulse total", rises, exp_p);
    chk(timeout_o == (k >= NTR), "R6 timeout flag", timeout_o, (k >= NTR));
    chk(rdata_o == exp_rd, "R7 read result", rdata_o, exp_rd);
    chk(hi_bad == 0 && lo_bad == 0, "R10 pulse shape", hi_bad + lo_bad, 0);
    chk(quiet(), "R8 port low at done", {cr_clk_o, cr_sel_o, cr_wr_en_o, cr_rd_en_o}, 0);
    if (wr) exp_mem[a[3:0]] = d;
    @(negedge clk_i); #1;
    chk(!done_o, "R8 done single cycle", done_o, 0);
    chk(quiet(), "R8 port low after done", {cr_clk_o, cr_sel_o}, 0);
    chk(rdata_o == exp_rd, "R7 read result held", rdata_o, exp_rd);
    if (inj) begin
      r0 = rises;
      repeat (300) @(negedge clk_i);
      #1;
      chk(done_cnt == 1, "R9 single done", done_cnt, 1);
      chk(rises == r0, "R9 no pulses after done", rises, r0);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    mon_clear();
    repeat (3) @(negedge clk_i);
    chk(quiet() && !done_o && !timeout_o && rdata_o == 0, "R8 reset state", {done_o, cr_clk_o, cr_sel_o}, 0);
    rst_ni = 1'b1;
    for (int k = 0; k <= 11; k++) begin
      do_txn(1'b1, 16'h5A00 | 16'(k), 16'hC3C0 ^ (16'(k) * 16'd37), k, 1'b0);
      do_txn(1'b0, 16'h5A00 | 16'(k), 16'h0000, k, 1'b0);
    end
    do_txn(1'b0, 16'h0E0E, 16'h0, 9, 1'b0);
    do_txn(1'b0, 16'h0003, 16'h0, 0, 1'b1);
    do_txn(1'b0, 16'h0005, 16'h0, 1, 1'b0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule